// File: doc/BRIEF.md
# ADC Register Front-End with Gated Power-Up

This block is the digital control face of one successive-approximation ADC. Software reaches it over a plain 32-bit register bus with a one-cycle read latency. It holds configuration, sampling-time, channel-select, sequence and differential-select storage. It also runs the power-up chain: leave deep power-down, turn on the regulator, wait for the regulator to be ready, enable, and wait for the converter to be ready. Only when that chain has finished does it launch a software-started conversion. The conversion goes to an external converter stub.

The stub receives a one-cycle start pulse and a channel number. Some cycles later it answers with a done pulse and a 16-bit result. The block raises end of conversion, latches the result, and clears the flag when software reads the data register. Each step of the chain is refused unless the step before it is complete. Losing an earlier step tears down the later ones.

Top module: `adc_regfront`

## Requirements
- R1: After reset the control register (0x08) reads 0x2000_0000, with deep power-down at bit 29 set. The status register (0x00) and the data register (0x40) read 0.
- R2: Configuration (0x0C) and the two sampling-time registers (0x14, 0x18) store all 32 bits. Channel preselect (0x1C) and differential select (0xC0) store bits 19:0 only. The sequence register (0x30) stores the channel at bits 10:6 and the length at bits 3:0. All other bits read 0, and an unmapped address reads 0.
- R3: Regulator ready (status bit 12) goes to 1 exactly VREG_DLY cycles after a control write leaves regulator enable (bit 28) at 1 and deep power-down at 0. It goes back to 0 when either of those conditions ends. When it goes to 0 it also clears enable and ADC ready.
- R4: A control write with deep power-down at 1 forces regulator enable to 0, whatever value is written to bit 28.
- R5: Writing enable (control bit 0) as 1 is ignored unless regulator ready is 1. Once enable is accepted it reads 1, and ADC ready (status bit 0) goes to 1 exactly RDY_DLY cycles after the write.
- R6: Writing start (control bit 2) as 1 is ignored in three cases: ADC ready is 0, a conversion is already in flight, or the sequence channel is 20 or more. An accepted start drives conv_start high for one cycle with conv_chan set to the sequence channel. Control bit 2 then reads 1 until the result arrives.
- R7: A conv_done pulse during a conversion does three things. It sets end of conversion (status bit 2). It loads conv_result into data register bits 15:0. It clears control bit 2.
- R8: Reading the data register clears end of conversion.
- R9: Writing disable (control bit 1) as 1 while enabled makes disable read 1 for one cycle. After that, disable, enable and ADC ready all read 0. Disable has no effect while the block is not enabled.
- R10: Writes to the status register are ignored. The boost bit (control bit 8) reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| conv_start | output | 1 | One-cycle start pulse to the converter stub |
| conv_chan | output | 5 | Channel to convert |
| conv_done | input | 1 | Converter stub result-valid pulse |
| conv_result | input | 16 | Converter stub result |

## Verification
The power chain is driven three ways. It is driven in the legal order, and it is driven out of order, with enable and start written before their prerequisites. It is also torn down both by disable and by deep power-down, so that a gating fault stands apart from a timing fault.

The ready flags are read one cycle before and one cycle after their exact rise cycle, which catches an off-by-one delay. Conversions are run on two channels with different result patterns. A start is also issued while a conversion is busy, and another with an out-of-range channel. Together these separate channel routing, result capture and the start qualification.

// File: rtl/adc_regfront_pkg.sv
package adc_regfront_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_SMP1 = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_SMP2 = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_PSEL = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_SEQ  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_DATA = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_DSEL = 8'hC0;

    localparam int unsigned CB_EN    = 0;
    localparam int unsigned CB_DIS   = 1;
    localparam int unsigned CB_START = 2;
    localparam int unsigned CB_BOOST = 8;
    localparam int unsigned CB_REGEN = 28;
    localparam int unsigned CB_DPD   = 29;

    localparam int unsigned SB_RDY  = 0;
    localparam int unsigned SB_EOC  = 2;
    localparam int unsigned SB_VREG = 12;

    localparam int unsigned SEQ_CH_LSB = 6;
    localparam int unsigned SEQ_LEN_W  = 4;

    typedef struct packed {
        logic dpd;
        logic regen;
        logic boost;
        logic start;
        logic dis;
        logic en;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(logic [DATA_W-1:0] d);
        ctrl_t c;
        c.dpd   = d[CB_DPD];
        c.regen = d[CB_REGEN];
        c.boost = d[CB_BOOST];
        c.start = d[CB_START];
        c.dis   = d[CB_DIS];
        c.en    = d[CB_EN];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c);
        logic [DATA_W-1:0] d;
        d = '0;
        d[CB_DPD]   = c.dpd;
        d[CB_REGEN] = c.regen;
        d[CB_BOOST] = c.boost;
        d[CB_START] = c.start;
        d[CB_DIS]   = c.dis;
        d[CB_EN]    = c.en;
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] pack_stat(logic vreg, logic eoc, logic rdy);
        logic [DATA_W-1:0] d;
        d = '0;
        d[SB_VREG] = vreg;
        d[SB_EOC]  = eoc;
        d[SB_RDY]  = rdy;
        return d;
    endfunction

endpackage

// File: rtl/adc_delay_cnt.sv
module adc_delay_cnt #(
    parameter int unsigned DLY = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int unsigned CNT_W = (DLY > 1) ? $clog2(DLY) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DLY - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == LAST) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_power_seq.sv
module adc_power_seq
    import adc_regfront_pkg::*;
#(
    parameter int unsigned VREG_DLY = 8,
    parameter int unsigned RDY_DLY  = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ctrl_wr,
    input  ctrl_t ctrl_wd,
    output logic  dpd,
    output logic  regen,
    output logic  boost,
    output logic  en,
    output logic  dis,
    output logic  vreg_rdy,
    output logic  adc_rdy
);
    localparam int unsigned NSTAGE = 2;

    logic [NSTAGE-1:0] stage_run;
    logic [NSTAGE-1:0] stage_done;

    assign stage_run[0] = regen & ~dpd;
    assign stage_run[1] = en & ~dis & vreg_rdy;
    assign vreg_rdy     = stage_done[0];
    assign adc_rdy      = stage_done[1];

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        adc_delay_cnt #(
            .DLY((i == 0) ? VREG_DLY : RDY_DLY)
        ) u_dly (
            .clk (clk),
            .rst (rst),
            .run (stage_run[i]),
            .done(stage_done[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dpd   <= 1'b1;
            regen <= 1'b0;
            boost <= 1'b0;
            en    <= 1'b0;
            dis   <= 1'b0;
        end else begin
            if (dis) begin
                dis <= 1'b0;
                en  <= 1'b0;
            end
            if (!vreg_rdy) begin
                en <= 1'b0;
            end
            if (ctrl_wr) begin
                dpd   <= ctrl_wd.dpd;
                regen <= ctrl_wd.regen & ~ctrl_wd.dpd;
                boost <= ctrl_wd.boost;
                if (ctrl_wd.en && vreg_rdy && !dis) begin
                    en <= 1'b1;
                end
                if (ctrl_wd.dis && en && !dis) begin
                    dis <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
    parameter int unsigned NUM_CH = 20,
    parameter int unsigned RES_W  = 16,
    parameter int unsigned CH_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             adc_rdy,
    input  logic [CH_W-1:0]  chan,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic             data_rd,
    output logic             busy,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    output logic             eoc,
    output logic [RES_W-1:0] data
);
    logic chan_ok;
    assign chan_ok = 32'(chan) < NUM_CH;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            conv_start <= 1'b0;
            conv_chan  <= '0;
            eoc        <= 1'b0;
            data       <= '0;
        end else begin
            conv_start <= 1'b0;
            if (start_req && adc_rdy && !busy && chan_ok) begin
                busy       <= 1'b1;
                conv_start <= 1'b1;
                conv_chan  <= chan;
            end
            if (conv_done && busy) begin
                busy <= 1'b0;
                eoc  <= 1'b1;
                data <= conv_result;
            end else if (data_rd) begin
                eoc <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_regfront.sv
module adc_regfront
    import adc_regfront_pkg::*;
#(
    parameter int unsigned NUM_CH   = 20,
    parameter int unsigned RES_W    = 16,
    parameter int unsigned VREG_DLY = 8,
    parameter int unsigned RDY_DLY  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        conv_start,
    output logic [$clog2(NUM_CH)-1:0]   conv_chan,
    input  logic                        conv_done,
    input  logic [RES_W-1:0]            conv_result
);
    localparam int unsigned CH_W = $clog2(NUM_CH);

    logic             dpd, regen, boost, en, dis, vreg_rdy, adc_rdy;
    logic             busy, eoc;
    logic [RES_W-1:0] data;
    logic             ctrl_wr, data_rd;
    ctrl_t            ctrl_wd, ctrl_rd;

    logic [DATA_W-1:0]    cfg_q, smp1_q, smp2_q;
    logic [NUM_CH-1:0]    psel_q, dsel_q;
    logic [CH_W-1:0]      seq_ch_q;
    logic [SEQ_LEN_W-1:0] seq_len_q;
    logic [DATA_W-1:0]    rd_mux;

    assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
    assign data_rd = bus_rd && (bus_addr == OFS_DATA);
    assign ctrl_wd = unpack_ctrl(bus_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            smp1_q    <= '0;
            smp2_q    <= '0;
            psel_q    <= '0;
            dsel_q    <= '0;
            seq_ch_q  <= '0;
            seq_len_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                OFS_CFG:  cfg_q  <= bus_wdata;
                OFS_SMP1: smp1_q <= bus_wdata;
                OFS_SMP2: smp2_q <= bus_wdata;
                OFS_PSEL: psel_q <= bus_wdata[NUM_CH-1:0];
                OFS_DSEL: dsel_q <= bus_wdata[NUM_CH-1:0];
                OFS_SEQ: begin
                    seq_ch_q  <= bus_wdata[SEQ_CH_LSB +: CH_W];
                    seq_len_q <= bus_wdata[SEQ_LEN_W-1:0];
                end
                default: ;
            endcase
        end
    end

    adc_power_seq #(
        .VREG_DLY(VREG_DLY),
        .RDY_DLY (RDY_DLY)
    ) u_pwr (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (ctrl_wr),
        .ctrl_wd (ctrl_wd),
        .dpd     (dpd),
        .regen   (regen),
        .boost   (boost),
        .en      (en),
        .dis     (dis),
        .vreg_rdy(vreg_rdy),
        .adc_rdy (adc_rdy)
    );

    adc_conv_ctrl #(
        .NUM_CH(NUM_CH),
        .RES_W (RES_W),
        .CH_W  (CH_W)
    ) u_conv (
        .clk        (clk),
        .rst        (rst),
        .start_req  (ctrl_wr && ctrl_wd.start),
        .adc_rdy    (adc_rdy),
        .chan       (seq_ch_q),
        .conv_done  (conv_done),
        .conv_result(conv_result),
        .data_rd    (data_rd),
        .busy       (busy),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .eoc        (eoc),
        .data       (data)
    );

    always_comb begin
        ctrl_rd.dpd   = dpd;
        ctrl_rd.regen = regen;
        ctrl_rd.boost = boost;
        ctrl_rd.start = busy;
        ctrl_rd.dis   = dis;
        ctrl_rd.en    = en;
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_STAT: rd_mux = pack_stat(vreg_rdy, eoc, adc_rdy);
            OFS_CTRL: rd_mux = pack_ctrl(ctrl_rd);
            OFS_CFG:  rd_mux = cfg_q;
            OFS_SMP1: rd_mux = smp1_q;
            OFS_SMP2: rd_mux = smp2_q;
            OFS_PSEL: rd_mux[NUM_CH-1:0] = psel_q;
            OFS_DSEL: rd_mux[NUM_CH-1:0] = dsel_q;
            OFS_SEQ: begin
                rd_mux[SEQ_CH_LSB +: CH_W]  = seq_ch_q;
                rd_mux[SEQ_LEN_W-1:0]       = seq_len_q;
            end
            OFS_DATA: rd_mux[RES_W-1:0] = data;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/adc_regfront_chk.sv
module adc_regfront_chk (
    input logic clk,
    input logic rst,
    input logic dpd,
    input logic regen,
    input logic vreg_rdy,
    input logic en,
    input logic dis,
    input logic adc_rdy,
    input logic conv_start,
    input logic busy,
    input logic conv_done,
    input logic eoc
);
    AST_VREG_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        $rose(vreg_rdy) |-> $past(regen && !dpd)); // R3

    AST_DPD_DROPS_VREG: assert property (@(posedge clk) disable iff (rst)
        dpd |=> !vreg_rdy); // R4

    AST_RDY_NEEDS_VREG: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_rdy) |-> $past(vreg_rdy && en)); // R5

    AST_START_NEEDS_RDY: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(adc_rdy) && busy); // R6

    AST_START_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start); // R6

    AST_DONE_SETS_EOC: assert property (@(posedge clk) disable iff (rst)
        (conv_done && busy) |=> eoc && !busy); // R7

    AST_DIS_TEARDOWN: assert property (@(posedge clk) disable iff (rst)
        dis |=> !dis && !en && !adc_rdy); // R9
endmodule

bind adc_regfront adc_regfront_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .dpd       (dpd),
    .regen     (regen),
    .vreg_rdy  (vreg_rdy),
    .en        (en),
    .dis       (dis),
    .adc_rdy   (adc_rdy),
    .conv_start(conv_start),
    .busy      (busy),
    .conv_done (conv_done),
    .eoc       (eoc)
);

// File: tb/adc_regfront_tb.sv
module adc_regfront_tb;
    localparam int unsigned VREG_DLY = 8;
    localparam int unsigned RDY_DLY  = 4;
    localparam int unsigned LAT      = 6;

    localparam logic [31:0] REGEN = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_start;
    logic [4:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [15:0] conv_result = '0;

    int checks = 0;
    int errors = 0;
    logic        last_start;
    logic [4:0]  last_chan;
    logic [31:0] rv;

    always #2 clk = ~clk;

    adc_regfront #(
        .NUM_CH(20), .RES_W(16), .VREG_DLY(VREG_DLY), .RDY_DLY(RDY_DLY)
    ) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_result(conv_result)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // all bus tasks start and end at a negative edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        last_start = conv_start; last_chan = conv_chan;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic stub_done(logic [15:0] res);
        idle(LAT);
        conv_done = 1'b1; conv_result = res;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic t_reset();
        rd(8'h08, rv); check("R1 ctrl", rv, 32'h2000_0000);
        rd(8'h00, rv); check("R1 status", rv, 32'h0);
        rd(8'h40, rv); check("R1 data", rv, 32'h0);
    endtask

    task automatic t_regs();
        wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, rv); check("R2 cfg", rv, 32'hFFFF_FFFF);
        wr(8'h14, 32'hA5A5_5A5A); rd(8'h14, rv); check("R2 smp1", rv, 32'hA5A5_5A5A);
        wr(8'h18, 32'h1234_5678); rd(8'h18, rv); check("R2 smp2", rv, 32'h1234_5678);
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, rv); check("R2 psel", rv, 32'h000F_FFFF);
        wr(8'hC0, 32'hFFFF_FFFF); rd(8'hC0, rv); check("R2 dsel", rv, 32'h000F_FFFF);
        wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, rv); check("R2 seq", rv, 32'h0000_07CF);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, rv); check("R2 unmapped", rv, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, rv); check("R10 status write", rv, 32'h0);
    endtask

    task automatic t_out_of_order();
        wr(8'h08, 32'h0000_0004);
        check("R6 start before ready", {31'b0, last_start}, 32'h0);
        wr(8'h08, 32'h0000_0001);
        rd(8'h08, rv); check("R5 enable before vreg", rv, 32'h0);
        wr(8'h08, 32'h3000_0100);
        rd(8'h08, rv); check("R4 dpd forces regen off, R10 boost", rv, 32'h2000_0100);
        wr(8'h08, 32'h0000_0000);
        rd(8'h08, rv); check("R10 boost cleared", rv, 32'h0);
    endtask

    task automatic t_power_up();
        wr(8'h08, REGEN);
        idle(VREG_DLY - 1);
        rd(8'h00, rv); check("R3 vreg one cycle early", rv, 32'h0);
        rd(8'h00, rv); check("R3 vreg on time", rv, 32'h0000_1000);
        wr(8'h08, REGEN | 32'h1);
        idle(RDY_DLY - 1);
        rd(8'h00, rv); check("R5 rdy one cycle early", rv, 32'h0000_1000);
        rd(8'h00, rv); check("R5 rdy on time", rv, 32'h0000_1001);
        rd(8'h08, rv); check("R5 enable reads 1", rv, 32'h1000_0001);
    endtask

    task automatic t_convert(logic [4:0] ch, logic [15:0] res);
        wr(8'h30, {21'b0, ch, 6'b0});
        wr(8'h08, REGEN | 32'h4);
        check("R6 start pulse", {31'b0, last_start}, 32'h1);
        check("R6 channel", {27'b0, last_chan}, {27'b0, ch});
        rd(8'h08, rv); check("R6 start bit busy", rv, 32'h1000_0005);
        wr(8'h08, REGEN | 32'h4);
        check("R6 start while busy", {31'b0, last_start}, 32'h0);
        stub_done(res);
        rd(8'h00, rv); check("R7 eoc set", rv, 32'h0000_1005);
        rd(8'h08, rv); check("R7 start cleared", rv, 32'h1000_0001);
        rd(8'h40, rv); check("R7 data", rv, {16'b0, res});
        rd(8'h00, rv); check("R8 eoc cleared by read", rv, 32'h0000_1001);
    endtask

    task automatic t_bad_channel();
        wr(8'h30, {21'b0, 5'd20, 6'b0});
        wr(8'h08, REGEN | 32'h4);
        check("R6 channel 20 refused", {31'b0, last_start}, 32'h0);
        rd(8'h08, rv); check("R6 no busy after refusal", rv, 32'h1000_0001);
    endtask

    task automatic t_disable();
        wr(8'h08, REGEN | 32'h2);
        rd(8'h08, rv); check("R9 disable visible", rv, 32'h1000_0003);
        rd(8'h08, rv); check("R9 disable done", rv, 32'h1000_0000);
        rd(8'h00, rv); check("R9 rdy dropped", rv, 32'h0000_1000);
        wr(8'h08, REGEN | 32'h2);
        rd(8'h08, rv); check("R9 disable when idle", rv, 32'h1000_0000);
    endtask

    task automatic t_deep_pd();
        wr(8'h08, REGEN | 32'h1);
        idle(RDY_DLY + 1);
        rd(8'h00, rv); check("R5 re-enable", rv, 32'h0000_1001);
        wr(8'h08, 32'h3000_0000);
        idle(2);
        rd(8'h00, rv); check("R3 teardown status", rv, 32'h0);
        rd(8'h08, rv); check("R4 teardown ctrl", rv, 32'h2000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_out_of_order();
        t_power_up();
        t_bad_channel();
        t_convert(5'd7, 16'hBEEF);
        t_convert(5'd19, 16'h1234);
        t_disable();
        t_deep_pd();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule